// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block sequences a dynamic (multiplexed) liquid-crystal panel with 32 segment lines and either three or four common lines, using one-third bias. It does not drive analog voltages. For every common and every segment pin it emits a 2-bit code. An external resistor ladder and output buffers turn each code into one of four drive levels. A slow oscillator tick, given as a single-cycle enable in the system clock domain, advances a slot counter and a frame counter.

The host presents four latched 32-bit display words, one per common, plus a display-enable flag and a duty select. In each time slot one common sits at a rail. Every segment takes its bit from the word that belongs to that common. Drive polarity reverses after each frame, so the panel sees no net DC. The frame always lasts 24 oscillator ticks. In the three-common mode each slot is 8 ticks long and the fourth common rests at ground. In the four-common mode each slot is 6 ticks long.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset the block runs four-common duty at slot 0 with positive polarity. Common 0 reads code 3 and every other common reads code 1, before any oscillator tick arrives.
- R2: In either duty, when the duty select is held steady, polarity inverts once every 24 oscillator ticks.
- R3: With `third_duty` high, commons 0 to 2 are selected in turn for 8 ticks each. With it low, commons 0 to 3 are selected in turn for 6 ticks each. Selection order is ascending and wraps to common 0.
- R4: While three-common duty is in force, the fourth common (bits 7:6 of `com_lvl`) holds code 0.
- R5: The level codes are 0 = ground, 1 = one-third, 2 = two-thirds and 3 = full supply. In a positive frame the selected common reads 3 and the other active commons read 1. In a negative frame they read 0 and 2.
- R6: During slot k, segment j (bits 2j+1:2j of `seg_lvl`) shows bit k*32+j of `lat_flat`. When that bit is on, the segment reads 0 in a positive frame and 3 in a negative frame. When it is off, it reads 2 in a positive frame and 1 in a negative frame.
- R7: While `disp_en` is low, every segment shows the off code of the current polarity, whatever the latch contents.
- R8: The common outputs and the polarity change only on a clock where `osc_en` is high, as long as the duty select is unchanged.
- R9: The duty select is taken on every clock. On the clock edge after it changes, the counters restart at slot 0 and tick 0, polarity is kept, and the new duty is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle oscillator tick |
| third_duty | input | 1 | 1 = three commons, 0 = four commons |
| disp_en | input | 1 | 0 forces all segments off |
| lat_flat | input | 128 | Four display words, word k in bits k*32+31:k*32 |
| com_lvl | output | 8 | Level code per common, common k in bits 2k+1:2k |
| seg_lvl | output | 64 | Level code per segment, segment j in bits 2j+1:2j |

## Verification
The bench builds the block with its default parameters: 32 segments, four commons and a 24-tick frame. With these values both slot lengths (6 and 8 ticks) occur, all four latch words are used, and the idle fourth common appears. The reference model steps through tick patterns ranging from a tick every clock to sparse ticks. It also switches duty in the middle of a frame, which exercises the restart path. Frame length is timed separately by counting ticks between polarity flips while the duty is steady.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
   typedef enum logic [1:0] {
      LV_GND = 2'd0,
      LV_LO  = 2'd1,
      LV_HI  = 2'd2,
      LV_TOP = 2'd3
   } lvl_e;
endpackage

// File: rtl/lcd_mux_timing.sv
module lcd_mux_timing #(
   parameter int COM_N     = 4,
   parameter int FRAME_CYC = 24,
   localparam int SLOT_W   = $clog2(COM_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_en,
   input  logic              third_duty,
   output logic              duty_q,
   output logic [SLOT_W-1:0] slot,
   output logic              neg_pol
);
   localparam int SLOT_FULL  = FRAME_CYC / COM_N;
   localparam int SLOT_SHORT = FRAME_CYC / (COM_N - 1);
   localparam int CYC_W      = $clog2(SLOT_SHORT);

   logic [CYC_W-1:0]  cyc;
   logic [CYC_W-1:0]  last_cyc;
   logic [SLOT_W-1:0] last_slot;

   always_comb begin
      last_cyc  = duty_q ? CYC_W'(SLOT_SHORT - 1) : CYC_W'(SLOT_FULL - 1);
      last_slot = duty_q ? SLOT_W'(COM_N - 2)     : SLOT_W'(COM_N - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q  <= 1'b0;
         cyc     <= '0;
         slot    <= '0;
         neg_pol <= 1'b0;
      end else if (third_duty != duty_q) begin
         duty_q <= third_duty;
         cyc    <= '0;
         slot   <= '0;
      end else if (osc_en) begin
         if (cyc >= last_cyc) begin
            cyc <= '0;
            if (slot >= last_slot) begin
               slot    <= '0;
               neg_pol <= ~neg_pol;
            end else begin
               slot <= slot + 1'b1;
            end
         end else begin
            cyc <= cyc + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lcd_mux_com.sv
module lcd_mux_com
   import lcd_mux_pkg::*;
#(
   parameter int COM_N    = 4,
   localparam int SLOT_W  = $clog2(COM_N)
) (
   input  logic               duty_q,
   input  logic [SLOT_W-1:0]  slot,
   input  logic               neg_pol,
   output logic [COM_N*2-1:0] com_lvl
);
   for (genvar k = 0; k < COM_N; k++) begin : g_com
      lvl_e code;
      logic sel;
      assign sel = (slot == SLOT_W'(k));
      if (k == COM_N - 1) begin : g_last
         always_comb begin
            if (duty_q)       code = LV_GND;
            else if (neg_pol) code = sel ? LV_GND : LV_HI;
            else              code = sel ? LV_TOP : LV_LO;
         end
      end else begin : g_norm
         always_comb begin
            if (neg_pol) code = sel ? LV_GND : LV_HI;
            else         code = sel ? LV_TOP : LV_LO;
         end
      end
      assign com_lvl[2*k +: 2] = code;
   end
endmodule

// File: rtl/lcd_mux_seg.sv
module lcd_mux_seg
   import lcd_mux_pkg::*;
#(
   parameter int SEG_W    = 32,
   parameter int COM_N    = 4,
   localparam int SLOT_W  = $clog2(COM_N)
) (
   input  logic [COM_N*SEG_W-1:0] lat_flat,
   input  logic [SLOT_W-1:0]      slot,
   input  logic                   neg_pol,
   input  logic                   disp_en,
   output logic [SEG_W*2-1:0]     seg_lvl
);
   logic [SEG_W-1:0] row;

   always_comb begin
      row = '0;
      for (int k = 0; k < COM_N; k++) begin
         if (slot == SLOT_W'(k)) row = lat_flat[k*SEG_W +: SEG_W];
      end
   end

   for (genvar j = 0; j < SEG_W; j++) begin : g_seg
      lvl_e code;
      logic on;
      assign on = row[j] & disp_en;
      always_comb begin
         if (neg_pol) code = on ? LV_TOP : LV_LO;
         else         code = on ? LV_GND : LV_HI;
      end
      assign seg_lvl[2*j +: 2] = code;
   end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
   parameter int SEG_W     = 32,
   parameter int COM_N     = 4,
   parameter int FRAME_CYC = 24
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   osc_en,
   input  logic                   third_duty,
   input  logic                   disp_en,
   input  logic [COM_N*SEG_W-1:0] lat_flat,
   output logic [COM_N*2-1:0]     com_lvl,
   output logic [SEG_W*2-1:0]     seg_lvl
);
   localparam int SLOT_W = $clog2(COM_N);

   if (COM_N < 3) begin : g_bad_com
      $error("COM_N must be at least 3");
   end
   if ((FRAME_CYC % COM_N) != 0 || (FRAME_CYC % (COM_N - 1)) != 0) begin : g_bad_frame
      $error("FRAME_CYC must divide by COM_N and COM_N-1");
   end
   if (FRAME_CYC / COM_N < 2) begin : g_bad_slot
      $error("slots must last at least two ticks");
   end
   if (SEG_W < 1) begin : g_bad_seg
      $error("SEG_W must be positive");
   end

   logic              duty_q;
   logic [SLOT_W-1:0] slot;
   logic              neg_pol;

   lcd_mux_timing #(.COM_N(COM_N), .FRAME_CYC(FRAME_CYC)) u_timing (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .third_duty(third_duty),
      .duty_q(duty_q), .slot(slot), .neg_pol(neg_pol)
   );

   lcd_mux_com #(.COM_N(COM_N)) u_com (
      .duty_q(duty_q), .slot(slot), .neg_pol(neg_pol), .com_lvl(com_lvl)
   );

   lcd_mux_seg #(.SEG_W(SEG_W), .COM_N(COM_N)) u_seg (
      .lat_flat(lat_flat), .slot(slot), .neg_pol(neg_pol),
      .disp_en(disp_en), .seg_lvl(seg_lvl)
   );
endmodule

// File: rtl/lcd_mux_chk.sv
module lcd_mux_chk #(
   parameter int SEG_W = 32,
   parameter int COM_N = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               osc_en,
   input logic               third_duty,
   input logic               duty_q,
   input logic               disp_en,
   input logic [COM_N*2-1:0] com_lvl,
   input logic [SEG_W*2-1:0] seg_lvl
);
   int   rail_cnt;
   logic seg_off_ok;
   logic parity_ok;

   always_comb begin
      rail_cnt   = 0;
      seg_off_ok = 1'b1;
      parity_ok  = 1'b1;
      for (int k = 0; k < COM_N; k++) begin
         if (!(duty_q && k == COM_N - 1)) begin
            if (com_lvl[2*k +: 2] == 2'd0 || com_lvl[2*k +: 2] == 2'd3) rail_cnt++;
            if (com_lvl[2*k] != com_lvl[0]) parity_ok = 1'b0;
         end
      end
      for (int j = 0; j < SEG_W; j++) begin
         if (seg_lvl[2*j +: 2] == 2'd0 || seg_lvl[2*j +: 2] == 2'd3) seg_off_ok = 1'b0;
         if (seg_lvl[2*j] == com_lvl[0]) parity_ok = 1'b0;
      end
   end

   // R4
   idle_com_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      duty_q |-> (com_lvl[2*COM_N-1 -: 2] == 2'd0));

   // R8
   com_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && third_duty == duty_q) |=> $stable(com_lvl));

   // R7
   blank_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |-> seg_off_ok);

   // R6
   polarity_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      parity_ok);

   // R5
   one_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rail_cnt == 1);
endmodule

bind lcd_mux_seq lcd_mux_chk #(.SEG_W(SEG_W), .COM_N(COM_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .third_duty(third_duty),
   .duty_q(duty_q), .disp_en(disp_en), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcd_mux_seq_bench.sv
`timescale 1ns/1ps
module lcd_mux_seq_bench;
   localparam int SEG_W = 32;
   localparam int COM_N = 4;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   osc_en = 1'b0;
   logic                   third_duty = 1'b0;
   logic                   disp_en = 1'b1;
   logic [COM_N*SEG_W-1:0] lat_flat = '0;
   logic [COM_N*2-1:0]     com_lvl;
   logic [SEG_W*2-1:0]     seg_lvl;

   int    checks = 0;
   int    fails = 0;
   int    cycles = 0;
   string phase = "R1";

   always #2 clk = ~clk;

   lcd_mux_seq u_lcd_mux_seq (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .third_duty(third_duty),
      .disp_en(disp_en), .lat_flat(lat_flat), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   // behavioural model state
   int m_tick, m_slot;
   bit m_neg, m_three;
   int pulses_since;
   bit span_valid;
   bit prev_par;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tick <= 0; m_slot <= 0; m_neg <= 0; m_three <= 0;
         pulses_since <= 0; span_valid <= 0;
      end else if (third_duty != m_three) begin
         m_three <= third_duty; m_tick <= 0; m_slot <= 0;
         span_valid <= 0;
      end else if (osc_en) begin
         pulses_since <= pulses_since + 1;
         if (m_tick == (m_three ? 7 : 5)) begin
            m_tick <= 0;
            if (m_slot == (m_three ? 2 : 3)) begin
               m_slot <= 0; m_neg <= ~m_neg;
            end else m_slot <= m_slot + 1;
         end else m_tick <= m_tick + 1;
      end
   end

   always @(negedge clk) begin
      logic [1:0] exp_c, exp_s;
      bit sel, on, par;
      cycles++;
      if (rst_n) begin
         for (int k = 0; k < COM_N; k++) begin
            sel = (m_slot == k);
            if (m_three && k == COM_N - 1) exp_c = 2'd0;
            else if (m_neg) exp_c = sel ? 2'd0 : 2'd2;
            else exp_c = sel ? 2'd3 : 2'd1;
            checks++;
            if (com_lvl[2*k +: 2] !== exp_c) begin
               fails++;
               $display("FAIL %s common %0d (phase %s): got %0d expected %0d",
                        (m_three && k == COM_N - 1) ? "R4" : "R5", k, phase,
                        com_lvl[2*k +: 2], exp_c);
            end
         end
         for (int j = 0; j < SEG_W; j++) begin
            on = lat_flat[m_slot*SEG_W + j] && disp_en;
            if (m_neg) exp_s = on ? 2'd3 : 2'd1;
            else exp_s = on ? 2'd0 : 2'd2;
            if (seg_lvl[2*j +: 2] !== exp_s) begin
               checks++; fails++;
               $display("FAIL %s segment %0d (phase %s): got %0d expected %0d",
                        disp_en ? "R6" : "R7", j, phase, seg_lvl[2*j +: 2], exp_s);
            end
         end
         checks++;
         // R2: ticks between polarity flips with a steady duty
         par = com_lvl[0];
         if (par != prev_par) begin
            if (span_valid) begin
               checks++;
               if (pulses_since != 24) begin
                  fails++;
                  $display("FAIL R2 frame length: got %0d expected 24", pulses_since);
               end
            end
            pulses_since = 0;
            span_valid = 1;
         end
         prev_par = par;
      end else begin
         prev_par = 1'b1;
      end
   end

   task automatic run(int n, int every);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         osc_en = (every > 0) && (i % every == 0);
      end
      @(posedge clk); #1;
      osc_en = 1'b0;
   endtask

   task automatic new_lat();
      for (int w = 0; w < COM_N; w++) lat_flat[w*SEG_W +: SEG_W] = $urandom;
   endtask

   initial begin
      new_lat();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      checks++;
      if (com_lvl !== 8'h57) begin
         fails++;
         $display("FAIL R1 commons in reset: got %h expected 57", com_lvl);
      end
      #1 rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (com_lvl !== 8'h57) begin
         fails++;
         $display("FAIL R1 commons after reset: got %h expected 57", com_lvl);
      end
      phase = "R5"; run(150, 1);
      phase = "R8"; run(240, 4);
      phase = "R3"; third_duty = 1'b1; run(200, 1);
      phase = "R3b"; new_lat(); run(200, 2);
      phase = "R7"; disp_en = 1'b0; run(100, 1);
      disp_en = 1'b1;
      phase = "R9";
      for (int r = 0; r < 6; r++) begin
         third_duty = ~third_duty;
         run(13 + 5*r, 1);
      end
      phase = "R2"; third_duty = 1'b0; new_lat(); run(200, 3);
      phase = "R6"; lat_flat = '1; run(60, 1);
      lat_flat = '0; run(60, 1);
      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule